// File: doc/BRIEF.md
# Per-Completer Bus Security Filter

This block sits on a single request channel in front of several downstream completers and decides, request by request, whether the access may reach its target. Each completer port has a fixed base/size address window and a policy mode fixed when the block is built. Secure-only ports take Secure traffic alone, and Non-secure-only ports take Non-secure traffic alone. Security-aware ports let everything through and leave isolation to the device. A boot-programmable port behaves as Secure or Non-secure according to a register that initialisation software writes, and it comes out of reset as Secure.

The security of a request comes from bit 1 of its protection field. A rejected request is never shown to any completer. Instead, the filter answers it locally with an error response. A small configuration port holds the boot-port settings and a per-requester override table. The override lets a legacy requester that drives a meaningless security bit be pinned to a programmed address space. Only Secure configuration writes take effect.

Top module: `sec_filter`

## Requirements
- R1: Protection bit 1 gives the request's address space: 0 is Secure, 1 is Non-secure. An allowed request shows up one cycle after acceptance on its port's `fwd_valid_o` bit only, with the same address, write flag and data. Its forwarded protection field carries the effective security bit at position 1.
- R2: A Secure-only port (mode code 0) forwards Secure requests. Every Non-secure request to it is faulted and never forwarded.
- R3: A Non-secure-only port (mode code 1) forwards Non-secure requests. Every Secure request to it is faulted and never forwarded.
- R4: A boot-programmable port (mode code 2) follows bit p of configuration register 0, where 1 means Non-secure. That bit resets to 0, so the port starts Secure. It forwards only requests whose effective security matches that setting.
- R5: A security-aware port (mode code 3) forwards every request, whatever its security.
- R6: Configuration register 1+r controls requester r. Bit 0 enables the override and bit 1 gives the forced security bit. While enabled, that value replaces the requester's protection bit 1, both for the policy decision and in the forwarded protection field.
- R7: A configuration write gets a response one cycle later. A Non-secure write returns SLVERR (2'b10) and changes nothing. A Secure write to an address above N_REQ returns DECERR (2'b11) and changes nothing. Any other Secure write returns OKAY (2'b00) and updates the register.
- R8: A request that hits a port but breaks that port's policy raises `err_valid_o` one cycle after acceptance, with `err_resp_o` = SLVERR (2'b10).
- R9: A request whose address lies in no port window raises `err_valid_o` one cycle after acceptance, with `err_resp_o` = DECERR (2'b11), and forwards nothing.
- R10: Every accepted request produces exactly one outcome in the following cycle: one port strobe, or the error strobe. No outcome appears without a request, and after reset all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle, always accepted |
| req_id_i | input | IDW | Index of the issuing requester |
| req_addr_i | input | AW | Request address |
| req_write_i | input | 1 | Write flag |
| req_wdata_i | input | DW | Write data |
| req_prot_i | input | 3 | Protection field, bit 1 = Non-secure |
| fwd_valid_o | output | N_PORTS | Per-port forward strobe |
| fwd_addr_o | output | AW | Forwarded address |
| fwd_write_o | output | 1 | Forwarded write flag |
| fwd_wdata_o | output | DW | Forwarded write data |
| fwd_prot_o | output | 3 | Forwarded protection, bit 1 effective security |
| err_valid_o | output | 1 | Local error response strobe |
| err_resp_o | output | 2 | Error code: 2'b10 policy, 2'b11 no match |
| cfg_valid_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CAW | Configuration register index |
| cfg_wdata_i | input | CFG_DW | Configuration write data |
| cfg_ns_i | input | 1 | Configuration write is Non-secure |
| cfg_resp_valid_o | output | 1 | Configuration response strobe |
| cfg_resp_o | output | 2 | Configuration response code |

## Verification
A wrong stored boot bit or override entry does not stay hidden. It shows at the ports on the next request that hits the affected port or comes from the affected requester. That request either goes to the wrong place or is faulted when it should not be, in the cycle after acceptance. A stale forwarded protection bit shows as a bit-1 mismatch on that same strobe. Non-secure configuration writes are followed right away by Secure traffic to the port they tried to open, so an ignored write that leaked through shows up within two cycles.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    MODE_SEC   = 2'd0,
    MODE_NS    = 2'd1,
    MODE_BOOT  = 2'd2,
    MODE_AWARE = 2'd3
  } port_mode_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;
  localparam int unsigned PROT_NS_BIT = 1;
endpackage

// File: rtl/sf_addr_dec.sv
module sf_addr_dec #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned AW      = 32,
  parameter logic [N_PORTS*AW-1:0] BASE = '0,
  parameter logic [N_PORTS*AW-1:0] SIZE = '0
) (
  input  logic [AW-1:0]      addr_i,
  output logic [N_PORTS-1:0] hit_o,
  output logic               any_o
);
  logic [N_PORTS-1:0] raw;
  logic               taken;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_win
    localparam logic [AW-1:0] B = BASE[p*AW +: AW];
    localparam logic [AW-1:0] S = SIZE[p*AW +: AW];
    assign raw[p] = (addr_i >= B) && ((addr_i - B) < S);
  end

  // overlapping windows: lowest index wins
  always_comb begin
    hit_o = '0;
    taken = 1'b0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (raw[p] && !taken) begin
        hit_o[p] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign any_o = |raw;
endmodule

// File: rtl/sf_cfg_regs.sv
module sf_cfg_regs
  import sf_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned N_REQ   = 4,
  parameter int unsigned CAW     = 3,
  parameter int unsigned CFG_DW  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_valid_i,
  input  logic [CAW-1:0]     cfg_addr_i,
  input  logic [CFG_DW-1:0]  cfg_wdata_i,
  input  logic               cfg_ns_i,
  output logic [N_PORTS-1:0] boot_ns_o,
  output logic [N_REQ-1:0]   ovr_en_o,
  output logic [N_REQ-1:0]   ovr_ns_o,
  output logic               cfg_resp_valid_o,
  output logic [1:0]         cfg_resp_o
);
  logic unmapped;
  assign unmapped = cfg_addr_i > CAW'(N_REQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_ns_o        <= '0;
      ovr_en_o         <= '0;
      ovr_ns_o         <= '0;
      cfg_resp_valid_o <= 1'b0;
      cfg_resp_o       <= RESP_OKAY;
    end else begin
      cfg_resp_valid_o <= cfg_valid_i;
      if (cfg_valid_i) begin
        if (cfg_ns_i)      cfg_resp_o <= RESP_SLVERR;
        else if (unmapped) cfg_resp_o <= RESP_DECERR;
        else begin
          cfg_resp_o <= RESP_OKAY;
          if (cfg_addr_i == '0) boot_ns_o <= cfg_wdata_i[N_PORTS-1:0];
          for (int r = 0; r < N_REQ; r++) begin
            if (cfg_addr_i == CAW'(r + 1)) begin
              ovr_en_o[r] <= cfg_wdata_i[0];
              ovr_ns_o[r] <= cfg_wdata_i[1];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sf_policy.sv
module sf_policy
  import sf_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter logic [N_PORTS*2-1:0] MODE = '0
) (
  input  logic [N_PORTS-1:0] hit_i,
  input  logic               ns_i,
  input  logic [N_PORTS-1:0] boot_ns_i,
  output logic               allow_o
);
  logic [N_PORTS-1:0] ok;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_pol
    localparam port_mode_e M = port_mode_e'(MODE[p*2 +: 2]);
    if (M == MODE_SEC)       begin : g_s assign ok[p] = !ns_i;               end
    else if (M == MODE_NS)   begin : g_n assign ok[p] = ns_i;                end
    else if (M == MODE_BOOT) begin : g_b assign ok[p] = ns_i == boot_ns_i[p]; end
    else                     begin : g_a assign ok[p] = 1'b1;                end
  end

  assign allow_o = |(hit_i & ok);
endmodule

// File: rtl/sec_filter.sv
module sec_filter
  import sf_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned N_REQ   = 4,
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned CFG_DW  = 8,
  parameter logic [N_PORTS*AW-1:0] PORT_BASE =
    {32'h0000_3000, 32'h0000_2000, 32'h0000_1000, 32'h0000_0000},
  parameter logic [N_PORTS*AW-1:0] PORT_SIZE =
    {32'h0000_1000, 32'h0000_1000, 32'h0000_1000, 32'h0000_1000},
  parameter logic [N_PORTS*2-1:0] PORT_MODE = 8'b11_10_01_00,
  localparam int unsigned IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int unsigned CAW = $clog2(N_REQ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [IDW-1:0]     req_id_i,
  input  logic [AW-1:0]      req_addr_i,
  input  logic               req_write_i,
  input  logic [DW-1:0]      req_wdata_i,
  input  logic [2:0]         req_prot_i,
  output logic [N_PORTS-1:0] fwd_valid_o,
  output logic [AW-1:0]      fwd_addr_o,
  output logic               fwd_write_o,
  output logic [DW-1:0]      fwd_wdata_o,
  output logic [2:0]         fwd_prot_o,
  output logic               err_valid_o,
  output logic [1:0]         err_resp_o,
  input  logic               cfg_valid_i,
  input  logic [CAW-1:0]     cfg_addr_i,
  input  logic [CFG_DW-1:0]  cfg_wdata_i,
  input  logic               cfg_ns_i,
  output logic               cfg_resp_valid_o,
  output logic [1:0]         cfg_resp_o
);
  logic [N_PORTS-1:0] boot_ns, hit;
  logic [N_REQ-1:0]   ovr_en, ovr_ns;
  logic               any_hit, allow, eff_ns;
  logic [2:0]         eff_prot;

  sf_cfg_regs #(.N_PORTS(N_PORTS), .N_REQ(N_REQ), .CAW(CAW), .CFG_DW(CFG_DW)) u_regs (
    .clk_i, .rst_ni, .cfg_valid_i, .cfg_addr_i, .cfg_wdata_i, .cfg_ns_i,
    .boot_ns_o(boot_ns), .ovr_en_o(ovr_en), .ovr_ns_o(ovr_ns),
    .cfg_resp_valid_o, .cfg_resp_o
  );

  sf_addr_dec #(.N_PORTS(N_PORTS), .AW(AW), .BASE(PORT_BASE), .SIZE(PORT_SIZE)) u_dec (
    .addr_i(req_addr_i), .hit_o(hit), .any_o(any_hit)
  );

  // legacy requester override replaces the incoming security bit
  assign eff_ns   = ovr_en[req_id_i] ? ovr_ns[req_id_i] : req_prot_i[PROT_NS_BIT];
  assign eff_prot = {req_prot_i[2], eff_ns, req_prot_i[0]};

  sf_policy #(.N_PORTS(N_PORTS), .MODE(PORT_MODE)) u_pol (
    .hit_i(hit), .ns_i(eff_ns), .boot_ns_i(boot_ns), .allow_o(allow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o <= '0;
      fwd_addr_o  <= '0;
      fwd_write_o <= 1'b0;
      fwd_wdata_o <= '0;
      fwd_prot_o  <= '0;
      err_valid_o <= 1'b0;
      err_resp_o  <= RESP_OKAY;
    end else begin
      fwd_valid_o <= (req_valid_i && allow) ? hit : '0;
      err_valid_o <= req_valid_i && !allow;
      if (req_valid_i) begin
        fwd_addr_o  <= req_addr_i;
        fwd_write_o <= req_write_i;
        fwd_wdata_o <= req_wdata_i;
        fwd_prot_o  <= eff_prot;
        err_resp_o  <= any_hit ? RESP_SLVERR : RESP_DECERR;
      end
    end
  end
endmodule

// File: rtl/sec_filter_chk.sv
module sec_filter_chk
  import sf_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned AW      = 32,
  parameter int unsigned CAW     = 3,
  parameter logic [N_PORTS*2-1:0] PORT_MODE = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [AW-1:0]      req_addr_i,
  input logic [N_PORTS-1:0] fwd_valid_o,
  input logic [AW-1:0]      fwd_addr_o,
  input logic [2:0]         fwd_prot_o,
  input logic               err_valid_o,
  input logic [1:0]         err_resp_o,
  input logic               cfg_valid_i,
  input logic               cfg_ns_i,
  input logic               cfg_resp_valid_o,
  input logic [1:0]         cfg_resp_o
);
  a_r10_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fwd_valid_o, err_valid_o}));
  a_r10_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (|fwd_valid_o) || err_valid_o);
  a_r10_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !(|fwd_valid_o) && !err_valid_o);
  a_r1_addr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (|fwd_valid_o) -> fwd_addr_o == $past(req_addr_i));
  a_r8_err_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> (err_resp_o == RESP_SLVERR || err_resp_o == RESP_DECERR));
  a_r7_cfg_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i |=> cfg_resp_valid_o);
  a_r7_ns_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_ns_i |=> cfg_resp_o == RESP_SLVERR);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    if (port_mode_e'(PORT_MODE[p*2 +: 2]) == MODE_SEC) begin : g_s
      a_r2_secure_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fwd_valid_o[p] |-> !fwd_prot_o[PROT_NS_BIT]);
    end else if (port_mode_e'(PORT_MODE[p*2 +: 2]) == MODE_NS) begin : g_n
      a_r3_nonsecure_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fwd_valid_o[p] |-> fwd_prot_o[PROT_NS_BIT]);
    end
  end
endmodule

bind sec_filter sec_filter_chk #(
  .N_PORTS(N_PORTS), .AW(AW), .CAW(CAW), .PORT_MODE(PORT_MODE)
) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .fwd_valid_o, .fwd_addr_o,
  .fwd_prot_o, .err_valid_o, .err_resp_o, .cfg_valid_i, .cfg_ns_i,
  .cfg_resp_valid_o, .cfg_resp_o
);

// File: tb/sim_sec_filter.sv
`timescale 1ns/1ps
module sim_sec_filter;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 0, req_write_i = 0;
  logic [1:0]  req_id_i = 0;
  logic [31:0] req_addr_i = 0, req_wdata_i = 0;
  logic [2:0]  req_prot_i = 0;
  logic [3:0]  fwd_valid_o;
  logic [31:0] fwd_addr_o, fwd_wdata_o;
  logic        fwd_write_o, err_valid_o, cfg_resp_valid_o;
  logic [2:0]  fwd_prot_o;
  logic [1:0]  err_resp_o, cfg_resp_o;
  logic        cfg_valid_i = 0, cfg_ns_i = 0;
  logic [2:0]  cfg_addr_i = 0;
  logic [7:0]  cfg_wdata_i = 0;

  int vectors = 0, miscompares = 0;
  logic [3:0] m_boot = '0;
  logic [3:0] m_oen = '0, m_ons = '0;

  always #2 clk_i = ~clk_i;

  sec_filter u0 (.*);

  // port p covers [p*0x1000, p*0x1000+0xFFF]; modes 0 sec,1 ns,2 boot,3 aware
  function automatic int port_of(input logic [31:0] a);
    return (a < 32'h4000) ? int'(a >> 12) : -1;
  endfunction

  function automatic bit allowed(input int p, input bit ns);
    case (p)
      0: return !ns;
      1: return ns;
      2: return ns == m_boot[2];
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input bit rv, input logic [1:0] id,
                       input logic [31:0] addr, input logic [2:0] prot,
                       input bit cv, input logic [2:0] ca, input logic [7:0] cd, input bit cns);
    int p; bit ns, ok; logic [3:0] e_fwd; logic [1:0] e_cresp;
    logic [31:0] wd = $urandom;
    @(negedge clk_i);
    req_valid_i = rv; req_id_i = id; req_addr_i = addr; req_prot_i = prot;
    req_write_i = wd[0]; req_wdata_i = wd;
    cfg_valid_i = cv; cfg_addr_i = ca; cfg_wdata_i = cd; cfg_ns_i = cns;
    p  = port_of(addr);
    ns = m_oen[id] ? m_ons[id] : prot[1];
    ok = rv && p >= 0 && allowed(p, ns);
    e_fwd = ok ? (4'b1 << p) : 4'b0;
    e_cresp = cns ? 2'b10 : (ca > 3'd4) ? 2'b11 : 2'b00;
    if (cv && !cns && ca == 0) m_boot = cd[3:0];
    if (cv && !cns && ca >= 1 && ca <= 4) begin m_oen[ca-1] = cd[0]; m_ons[ca-1] = cd[1]; end
    @(negedge clk_i);
    req_valid_i = 0; cfg_valid_i = 0;
    check(tag, "fwd_valid", 32'(fwd_valid_o), 32'(e_fwd));
    check(tag, "err_valid", 32'(err_valid_o), 32'(rv && !ok));
    if (ok) begin
      check(tag, "fwd_addr", fwd_addr_o, addr);
      check(tag, "fwd_wdata", fwd_wdata_o, wd);
      check(tag, "fwd_prot", 32'(fwd_prot_o), 32'({prot[2], ns, prot[0]}));
    end
    if (rv && !ok) check(tag, "err_resp", 32'(err_resp_o), (p < 0) ? 32'h3 : 32'h2);
    check(tag, "cfg_resp_valid", 32'(cfg_resp_valid_o), 32'(cv));
    if (cv) check(tag, "cfg_resp", 32'(cfg_resp_o), 32'(e_cresp));
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10", "reset fwd", 32'(fwd_valid_o), 0);
    check("R10", "reset err", 32'(err_valid_o), 0);
    check("R10", "reset cfg", 32'(cfg_resp_valid_o), 0);
    // directed
    apply("R2", 1, 0, 32'h0010, 3'b000, 0, 0, 0, 0);
    apply("R2", 1, 0, 32'h0ffc, 3'b010, 0, 0, 0, 0);
    apply("R3", 1, 0, 32'h1000, 3'b010, 0, 0, 0, 0);
    apply("R8", 1, 0, 32'h1ffc, 3'b101, 0, 0, 0, 0);
    apply("R4", 1, 0, 32'h2000, 3'b010, 0, 0, 0, 0);
    apply("R4", 1, 0, 32'h2004, 3'b000, 0, 0, 0, 0);
    apply("R7", 0, 0, 0, 0, 1, 3'd0, 8'h04, 1);
    apply("R7", 1, 0, 32'h2008, 3'b000, 0, 0, 0, 0);
    apply("R7", 0, 0, 0, 0, 1, 3'd6, 8'h04, 0);
    apply("R7", 1, 0, 32'h200c, 3'b000, 0, 0, 0, 0);
    apply("R4", 0, 0, 0, 0, 1, 3'd0, 8'h04, 0);
    apply("R4", 1, 0, 32'h2010, 3'b010, 0, 0, 0, 0);
    apply("R4", 1, 0, 32'h2014, 3'b000, 0, 0, 0, 0);
    apply("R5", 1, 3, 32'h3000, 3'b010, 0, 0, 0, 0);
    apply("R5", 1, 3, 32'h3ffc, 3'b000, 0, 0, 0, 0);
    apply("R6", 0, 0, 0, 0, 1, 3'd2, 8'h01, 0);
    apply("R6", 1, 1, 32'h0020, 3'b010, 0, 0, 0, 0);
    apply("R6", 1, 1, 32'h1020, 3'b010, 0, 0, 0, 0);
    apply("R6", 1, 2, 32'h0020, 3'b010, 0, 0, 0, 0);
    apply("R6", 0, 0, 0, 0, 1, 3'd2, 8'h03, 0);
    apply("R6", 1, 1, 32'h3020, 3'b000, 0, 0, 0, 0);
    apply("R9", 1, 0, 32'h4000, 3'b000, 0, 0, 0, 0);
    apply("R9", 1, 2, 32'hffff_fff0, 3'b010, 0, 0, 0, 0);
    // random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = $urandom_range(32'h4fff, 0);
      bit cv = ($urandom_range(4, 0) == 0);
      apply("R1", $urandom_range(3, 0) != 0, 2'($urandom), a, 3'($urandom),
            cv, 3'($urandom), 8'($urandom), 1'($urandom));
    end
    apply("R10", 0, 0, 32'h0, 3'b000, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule